// File: doc/BRIEF.md
# PHY Register Access Bridge

This block gives host software one 32-bit command/response word, at host byte offset 24h, for reading and writing the small register file of an attached physical-layer device. Software writes a 4-bit PHY register address, an 8-bit write value and one or both request strobes into the upper (command) half. The bridge then presents the request on a valid/ready handshake toward the PHY interface logic and clears each strobe as its request is accepted.

Register values coming back from the PHY side arrive on a single-cycle response strobe. The bridge stores the source address and the data in the lower (response) half and raises an interrupt flag. Any PHY-originated value sets the flag, whether or not a read was requested. The host and the PHY update their own halves independently, in any cycle.

Bits are numbered here with bit 0 as the most significant bit of the word. In the port vectors this means `word[31]` is bit 0.

Top module: `phy_reg_bridge`

## Requirements
- R1: After `rst_ni` is asserted, the word reads 0000_0000h, `req_valid_o` is 0 and `irq_o` is 0.
- R2: While `host_addr_i` equals 24h, `host_rdata_o` returns the word: [31] read strobe, [30] write strobe, [29:28] reserved, [27:24] command address, [23:16] write data, [15:12] reserved, [11:8] received address, [7:0] received data. Any other address reads zero.
- R3: A pending read strobe drives `req_valid_o`=1 and `req_is_write_o`=0, with `req_addr_o` taken from the command address. Type, address and data stay stable until the edge where `req_ready_i` is 1, and that edge clears the read strobe.
- R4: A pending write strobe (and no pending read strobe) drives `req_valid_o`=1 and `req_is_write_o`=1, with the command address and data on `req_addr_o`/`req_data_o`. The accepting edge clears the write strobe.
- R5: When both strobes are set by one host write, the read request is issued first. The write request follows once the read is accepted.
- R6: A host write to 24h is ignored entirely while either strobe is pending at the time of the write.
- R7: A cycle with `rsp_valid_i`=1 loads `rsp_addr_i` and `rsp_data_i` into the received fields and sets `irq_o` on the next edge, with or without a prior read.
- R8: `irq_ack_i`=1 clears `irq_o` on the next edge, unless `rsp_valid_i` is also 1 in that cycle, in which case `irq_o` stays 1.
- R9: Host writes never change the response half. The reserved bits always read as zero.
- R10: A host write to the command half and a PHY response in the same cycle both take effect.
- R11: Host writes to any address other than 24h change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 8 | Host byte address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data (combinational) |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Register-information-received interrupt |
| req_valid_o | output | 1 | PHY request valid |
| req_ready_i | input | 1 | PHY request ready |
| req_is_write_o | output | 1 | Request type, 1 = write |
| req_addr_o | output | 4 | PHY register address |
| req_data_o | output | 8 | PHY register write data |
| rsp_valid_i | input | 1 | PHY returned-register strobe |
| rsp_addr_i | input | 4 | Returned register address |
| rsp_data_i | input | 8 | Returned register data |

## Verification
The bench sets both strobes at once and holds ready low. A bridge that issued the write first, or dropped one strobe, would show the wrong `req_is_write_o` or lose a request. It rewrites the command half while a request is stalled; a design that accepted the write would change `req_addr_o` under a valid request. It also pairs an acknowledge with a response in the same cycle, and a host write with a response in the same cycle. Wrong priority would lose the interrupt or one of the two updates. Writes of all ones to the response half and the reserved bits would show up on readback if any of them were stored.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;
  localparam int WORD_W   = 32;
  localparam int PHY_AW   = 4;
  localparam int PHY_DW   = 8;
  // word[31] is bit 0 of the register
  localparam int RD_STB   = WORD_W - 1;
  localparam int WR_STB   = WORD_W - 2;
  localparam int CMD_A_LO = 24;
  localparam int CMD_D_LO = CMD_A_LO - PHY_DW;
  localparam int RX_D_LO  = 0;
  localparam int RX_A_LO  = RX_D_LO + PHY_DW;
  localparam logic [WORD_W-1:0] RSV_MASK = 32'h3000_F000;

  typedef enum logic {REQ_READ = 1'b0, REQ_WRITE = 1'b1} req_kind_e;

  typedef struct packed {
    logic              rd_pend;
    logic              wr_pend;
    logic [PHY_AW-1:0] addr;
    logic [PHY_DW-1:0] data;
  } cmd_t;

  typedef struct packed {
    logic [PHY_AW-1:0] addr;
    logic [PHY_DW-1:0] data;
  } rsp_t;

  function automatic logic [WORD_W-1:0] pack_word(cmd_t c, rsp_t r);
    logic [WORD_W-1:0] w;
    w = '0;
    w[RD_STB] = c.rd_pend;
    w[WR_STB] = c.wr_pend;
    w[CMD_A_LO +: PHY_AW] = c.addr;
    w[CMD_D_LO +: PHY_DW] = c.data;
    w[RX_A_LO +: PHY_AW]  = r.addr;
    w[RX_D_LO +: PHY_DW]  = r.data;
    return w;
  endfunction
endpackage

// File: rtl/phy_cmd_reg.sv
module phy_cmd_reg
  import phy_bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              accept_i,
  input  logic              accept_wr_i,
  output cmd_t              cmd_o
);
  cmd_t cmd_q;
  logic busy;

  assign busy  = cmd_q.rd_pend | cmd_q.wr_pend;
  assign cmd_o = cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (wr_en_i && !busy) begin
      // idle: nothing can be accepted this cycle
      cmd_q.rd_pend <= wdata_i[RD_STB];
      cmd_q.wr_pend <= wdata_i[WR_STB];
      cmd_q.addr    <= wdata_i[CMD_A_LO +: PHY_AW];
      cmd_q.data    <= wdata_i[CMD_D_LO +: PHY_DW];
    end else if (accept_i) begin
      if (accept_wr_i) cmd_q.wr_pend <= 1'b0;
      else             cmd_q.rd_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/phy_req_arb.sv
module phy_req_arb
  import phy_bridge_pkg::*;
(
  input  cmd_t              cmd_i,
  input  logic              ready_i,
  output logic              valid_o,
  output req_kind_e         kind_o,
  output logic [PHY_AW-1:0] addr_o,
  output logic [PHY_DW-1:0] data_o,
  output logic              accept_o,
  output logic              accept_wr_o
);
  always_comb begin
    valid_o     = cmd_i.rd_pend | cmd_i.wr_pend;
    kind_o      = cmd_i.rd_pend ? REQ_READ : REQ_WRITE;  // read wins
    addr_o      = cmd_i.addr;
    data_o      = cmd_i.data;
    accept_o    = valid_o & ready_i;
    accept_wr_o = (kind_o == REQ_WRITE);
  end
endmodule

// File: rtl/phy_rsp_reg.sv
module phy_rsp_reg
  import phy_bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rsp_valid_i,
  input  logic [PHY_AW-1:0] rsp_addr_i,
  input  logic [PHY_DW-1:0] rsp_data_i,
  input  logic              ack_i,
  output rsp_t              rsp_o,
  output logic              irq_o
);
  rsp_t rsp_q;
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q <= '0;
      irq_q <= 1'b0;
    end else if (rsp_valid_i) begin
      rsp_q.addr <= rsp_addr_i;
      rsp_q.data <= rsp_data_i;
      irq_q      <= 1'b1;  // new info beats ack
    end else if (ack_i) begin
      irq_q <= 1'b0;
    end
  end

  assign rsp_o = rsp_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge
  import phy_bridge_pkg::*;
#(
  parameter int              HOST_AW    = 8,
  parameter logic [HOST_AW-1:0] REG_OFFSET = 8'h24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_wr_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [WORD_W-1:0]  host_wdata_i,
  output logic [WORD_W-1:0]  host_rdata_o,
  input  logic               irq_ack_i,
  output logic               irq_o,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic               req_is_write_o,
  output logic [PHY_AW-1:0]  req_addr_o,
  output logic [PHY_DW-1:0]  req_data_o,
  input  logic               rsp_valid_i,
  input  logic [PHY_AW-1:0]  rsp_addr_i,
  input  logic [PHY_DW-1:0]  rsp_data_i
);
  logic      sel, wr_en, accept, accept_wr;
  cmd_t      cmd;
  rsp_t      rsp;
  req_kind_e kind;

  assign sel   = (host_addr_i == REG_OFFSET);
  assign wr_en = host_wr_i & sel;

  phy_cmd_reg u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wdata_i     (host_wdata_i),
    .accept_i    (accept),
    .accept_wr_i (accept_wr),
    .cmd_o       (cmd)
  );

  phy_req_arb u_arb (
    .cmd_i       (cmd),
    .ready_i     (req_ready_i),
    .valid_o     (req_valid_o),
    .kind_o      (kind),
    .addr_o      (req_addr_o),
    .data_o      (req_data_o),
    .accept_o    (accept),
    .accept_wr_o (accept_wr)
  );

  phy_rsp_reg u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rsp_valid_i (rsp_valid_i),
    .rsp_addr_i  (rsp_addr_i),
    .rsp_data_i  (rsp_data_i),
    .ack_i       (irq_ack_i),
    .rsp_o       (rsp),
    .irq_o       (irq_o)
  );

  assign req_is_write_o = (kind == REQ_WRITE);
  assign host_rdata_o   = sel ? pack_word(cmd, rsp) : '0;
endmodule

// File: rtl/phy_reg_bridge_chk.sv
module phy_reg_bridge_chk
  import phy_bridge_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] host_rdata_o,
  input logic              irq_ack_i,
  input logic              irq_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic              req_is_write_o,
  input logic [PHY_AW-1:0] req_addr_o,
  input logic [PHY_DW-1:0] req_data_o,
  input logic              rsp_valid_i,
  input logic [PHY_AW-1:0] rsp_addr_i,
  input logic [PHY_DW-1:0] rsp_data_i,
  input cmd_t              cmd,
  input rsp_t              rsp
);
  p_req_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_is_write_o)
      && $stable(req_addr_o) && $stable(req_data_o));

  p_rd_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i && !req_is_write_o |=> !cmd.rd_pend);

  p_wr_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i && req_is_write_o |=> !cmd.wr_pend);

  p_read_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd.rd_pend && cmd.wr_pend |-> req_valid_o && !req_is_write_o);

  p_rsp_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |=> irq_o && rsp.addr == $past(rsp_addr_i) && rsp.data == $past(rsp_data_i));

  p_ack_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i && !rsp_valid_i |=> !irq_o);

  p_rsp_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_i |=> $stable(rsp));

  p_rsv_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rdata_o & RSV_MASK) == '0);
endmodule

bind phy_reg_bridge phy_reg_bridge_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .host_rdata_o   (host_rdata_o),
  .irq_ack_i      (irq_ack_i),
  .irq_o          (irq_o),
  .req_valid_o    (req_valid_o),
  .req_ready_i    (req_ready_i),
  .req_is_write_o (req_is_write_o),
  .req_addr_o     (req_addr_o),
  .req_data_o     (req_data_o),
  .rsp_valid_i    (rsp_valid_i),
  .rsp_addr_i     (rsp_addr_i),
  .rsp_data_i     (rsp_data_i),
  .cmd            (cmd),
  .rsp            (rsp)
);

// File: tb/sim_phy_reg_bridge.sv
`timescale 1ns/1ps
module sim_phy_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_addr = 8'h24;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        irq_ack = 1'b0, irq;
  logic        req_valid, req_ready = 1'b0, req_is_write;
  logic [3:0]  req_addr;
  logic [7:0]  req_data;
  logic        rsp_valid = 1'b0;
  logic [3:0]  rsp_addr = '0;
  logic [7:0]  rsp_data = '0;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference state
  bit       m_rd, m_wr, m_irq;
  bit [3:0] m_a, m_rxa;
  bit [7:0] m_d, m_rxd;

  always #2 clk = ~clk;

  phy_reg_bridge u0 (
    .clk_i(clk), .rst_ni(rst_ni), .host_wr_i(host_wr), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata), .irq_ack_i(irq_ack),
    .irq_o(irq), .req_valid_o(req_valid), .req_ready_i(req_ready),
    .req_is_write_o(req_is_write), .req_addr_o(req_addr), .req_data_o(req_data),
    .rsp_valid_i(rsp_valid), .rsp_addr_i(rsp_addr), .rsp_data_i(rsp_data)
  );

  function automatic bit [31:0] exp_word();
    return {m_rd, m_wr, 2'b00, m_a, m_d, 4'h0, m_rxa, m_rxd};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk(req_valid === (m_rd | m_wr), "R3 req_valid", 32'(req_valid), 32'(m_rd | m_wr));
    if (m_rd | m_wr) begin
      chk(req_is_write === !m_rd, "R4 req_is_write", 32'(req_is_write), 32'(!m_rd));
      chk(req_addr === m_a, "R3 req_addr", 32'(req_addr), 32'(m_a));
      if (!m_rd) chk(req_data === m_d, "R4 req_data", 32'(req_data), 32'(m_d));
    end
    chk(irq === m_irq, "R8 irq", 32'(irq), 32'(m_irq));
    chk(host_rdata === (host_addr == 8'h24 ? exp_word() : 32'h0), "R2 readback",
        host_rdata, host_addr == 8'h24 ? exp_word() : 32'h0);
    chk((host_rdata & 32'h3000_F000) == 0, "R9 reserved zero", host_rdata, 32'h0);
  endtask

  task automatic step(input bit wr, input bit [7:0] ha, input bit [31:0] wd, input bit rdy,
                      input bit rv, input bit [3:0] ra, input bit [7:0] rd, input bit ack);
    bit busy;
    @(negedge clk);
    host_wr = wr; host_addr = ha; host_wdata = wd; req_ready = rdy;
    rsp_valid = rv; rsp_addr = ra; rsp_data = rd; irq_ack = ack;
    #1 check_outputs();
    @(posedge clk);
    busy = m_rd | m_wr;
    if (wr && ha == 8'h24 && !busy) begin
      m_rd = wd[31]; m_wr = wd[30]; m_a = wd[27:24]; m_d = wd[23:16];
    end else if (busy && rdy) begin
      if (m_rd) m_rd = 0; else m_wr = 0;
    end
    if (rv) begin m_rxa = ra; m_rxd = rd; m_irq = 1; end
    else if (ack) m_irq = 0;
  endtask

  task automatic idle(input bit rdy);
    step(0, 8'h24, 0, rdy, 0, 0, 0, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk(host_rdata === 0, "R1 reset word", host_rdata, 0);
    chk(req_valid === 0 && irq === 0, "R1 reset outputs", {req_valid, irq}, 0);
    @(negedge clk) rst_ni = 1'b1;

    // R5: both strobes, read first, held while ready is low (R3)
    step(1, 8'h24, 32'hC5A5_0000, 0, 0, 0, 0, 0);
    #1 chk(req_valid && !req_is_write && req_addr == 4'h5, "R5 read first",
           {req_valid, req_is_write, req_addr}, {1'b1, 1'b0, 4'h5});
    // R6: host rewrite while pending is ignored
    step(1, 8'h24, 32'h4C3C_0000, 0, 0, 0, 0, 0);
    #1 chk(req_addr == 4'h5 && !req_is_write, "R6 busy write ignored", req_addr, 4'h5);
    step(0, 8'h24, 0, 1, 0, 0, 0, 0);
    #1 chk(req_valid && req_is_write && req_data == 8'hA5, "R5 write follows",
           {req_valid, req_is_write, req_data}, {1'b1, 1'b1, 8'hA5});
    step(0, 8'h24, 0, 1, 0, 0, 0, 0);
    #1 chk(!req_valid, "R4 strobe cleared", req_valid, 0);

    // R11: other offset
    step(1, 8'h28, 32'hC000_0000, 0, 0, 0, 0, 0);
    #1 chk(!req_valid, "R11 other offset ignored", req_valid, 0);

    // R9: response half and reserved bits not writable
    step(1, 8'h24, 32'h3700_FFFF, 0, 0, 0, 0, 0);
    idle(0);

    // R7: unsolicited response sets irq
    step(0, 8'h24, 0, 0, 1, 4'h9, 8'h3E, 0);
    #1 chk(irq && host_rdata[11:0] == 12'h93E, "R7 capture", host_rdata, 32'h0000_093E);

    // R8: ack and response together keep irq
    step(0, 8'h24, 0, 0, 1, 4'h2, 8'h11, 1);
    #1 chk(irq === 1, "R8 ack vs rsp", irq, 1);
    step(0, 8'h24, 0, 0, 0, 0, 0, 1);
    #1 chk(irq === 0, "R8 ack clears", irq, 0);

    // R10: host command write and response in one cycle
    step(1, 8'h24, 32'h4B77_0000, 0, 1, 4'hC, 8'hD4, 0);
    #1 chk(host_rdata == 32'h4B77_0CD4, "R10 concurrent", host_rdata, 32'h4B77_0CD4);
    idle(1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit wr, rv, ack, rdy;
      bit [7:0] ha;
      bit [31:0] wd;
      wr  = ($urandom % 4) == 0;
      ha  = ($urandom % 4) != 0 ? 8'h24 : 8'($urandom);
      wd  = $urandom;
      rdy = $urandom % 2;
      rv  = ($urandom % 8) == 0;
      ack = ($urandom % 8) == 0;
      step(wr, ha, wd, rdy, rv, 4'($urandom), 8'($urandom), ack);
    end
    idle(0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule